// File: doc/BRIEF.md
# PHY Status Word Register

This block holds the read-only status word that a 10/100 Ethernet transceiver's management register file returns at address 0x10. It gathers indications from the receive path, the negotiation logic, the polarity detector and the interrupt logic into one 16-bit word. The word mixes three kinds of bit. Live bits follow an input directly. Latch-high bits record a one-cycle event and keep it. Latch-low bits record any drop of a level input and keep it.

Most sticky bits in this word do not clear when the word itself is read. Each one clears when the management side reads a different register address, the one that owns the matching counter or flag. The latch-low bits re-arm when the word is read. A read is a one-cycle strobe together with a 5-bit address. The registered read data appears in the following cycle. It is zero for any address other than 0x10.

Top module: `phy_status_bank`

## Requirements
- R1: While `rst` is high, all stored state and `rd_data` are 0. Events that arrive during reset are not kept.
- R2: `rd_data` is registered. In the cycle after a strobe with address 0x10, it shows the status word as it stood in the strobe cycle. In every other cycle it is 0. Bit 15 of the word always reads 0.
- R3: Bit 14 equals `mdix_swapped` in the strobe cycle: 1 means the pairs are swapped, 0 means normal.
- R4: Bit 13 sets on `rx_err_pulse` and holds until address 0x15 is read.
- R5: Bit 12 sets on `pol_inv_pulse` and clears only on a read of address 0x1A.
- R6: Bit 11 sets on `false_carrier_pulse` and clears on a read of address 0x14.
- R7: Bit 10 (`sig_det`) and bit 9 (`dscr_lock`) are latch-low. A read of 0x10 loads each held bit from its live input. In any other cycle, a held bit drops to 0 when its input is low and then stays 0. After reset both held bits are 0.
- R8: Bit 8 sets on `page_rcvd_pulse` and clears on a read of address 0x06.
- R9: Bit 7 sets on `irq_pulse` and clears on a read of address 0x12.
- R10: Bit 6 (`rem_fault_pulse`) and bit 5 (`jabber_pulse`) each set on their event. Both clear on a read of address 0x01.
- R11: When a set event and the clearing read of the same bit fall in one cycle, the bit ends up set.
- R12: Reading 0x10 never clears bits 13, 12, 11, 8, 7, 6 or 5, and no other address except each bit's own clearing address does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Management read strobe, one cycle |
| rd_addr | input | 5 | Register address of the read |
| rd_data | output | 16 | Registered status word, 0 unless address 0x10 was read |
| mdix_swapped | input | 1 | Live crossover state |
| rx_err_pulse | input | 1 | Receive error event |
| pol_inv_pulse | input | 1 | Inverted polarity detected event |
| false_carrier_pulse | input | 1 | False carrier event |
| sig_det | input | 1 | 100BASE-TX signal detect level |
| dscr_lock | input | 1 | Descrambler lock level |
| page_rcvd_pulse | input | 1 | Negotiation page received event |
| irq_pulse | input | 1 | Interrupt raised event |
| rem_fault_pulse | input | 1 | Link partner remote fault event |
| jabber_pulse | input | 1 | Jabber detected event |

## Verification
The hardest case to reach is a clearing read that coincides with a new event on the same bit, while the latch-low inputs are moving at the same time. The bench covers it in two ways. First, it sweeps every sticky bit against all 32 read addresses, with the live inputs toggled from the address bits. Second, it fires each event in the same cycle as its own clearing read and then reads the word.

// File: rtl/phy_status_pkg.sv
package phy_status_pkg;
  localparam int REG_ADDR_W = 5;
  localparam int WORD_W     = 16;
  localparam int N_STICKY   = 7;
  localparam int N_LOWLATCH = 2;

  localparam logic [REG_ADDR_W-1:0] ADR_STATUS  = 5'h10;
  localparam logic [REG_ADDR_W-1:0] ADR_BASIC   = 5'h01;
  localparam logic [REG_ADDR_W-1:0] ADR_NEG_EXP = 5'h06;
  localparam logic [REG_ADDR_W-1:0] ADR_IRQ     = 5'h12;
  localparam logic [REG_ADDR_W-1:0] ADR_FC_CNT  = 5'h14;
  localparam logic [REG_ADDR_W-1:0] ADR_RXE_CNT = 5'h15;
  localparam logic [REG_ADDR_W-1:0] ADR_TEN_ST  = 5'h1A;

  localparam int POS_RSVD   = 15;
  localparam int POS_XOVER  = 14;
  localparam int POS_LOCK   = 9;
  localparam int POS_SIGDET = 10;

  // Sticky slot order: 0 jabber, 1 remote fault, 2 irq, 3 page,
  // 4 false carrier, 5 polarity, 6 receive error
  function automatic int sticky_pos(input int idx);
    case (idx)
      0: return 5;
      1: return 6;
      2: return 7;
      3: return 8;
      4: return 11;
      5: return 12;
      default: return 13;
    endcase
  endfunction

  function automatic logic [REG_ADDR_W-1:0] sticky_clr_addr(input int idx);
    case (idx)
      0, 1: return ADR_BASIC;
      2: return ADR_IRQ;
      3: return ADR_NEG_EXP;
      4: return ADR_FC_CNT;
      5: return ADR_TEN_ST;
      default: return ADR_RXE_CNT;
    endcase
  endfunction
endpackage

// File: rtl/status_latch_hi.sv
module status_latch_hi #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_cell
      always_ff @(posedge clk) begin
        if (rst)
          q[gi] <= 1'b0;
        else if (set_evt[gi])
          q[gi] <= 1'b1;   // set has priority over a same-cycle clear
        else if (clr[gi])
          q[gi] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/status_latch_lo.sv
module status_latch_lo #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] live,
  input  logic         rearm,
  output logic [N-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_cell
      always_ff @(posedge clk) begin
        if (rst)
          q[gi] <= 1'b0;
        else if (rearm)
          q[gi] <= live[gi];
        else
          q[gi] <= q[gi] & live[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/status_word_pack.sv
module status_word_pack
  import phy_status_pkg::*;
(
  input  logic                  xover,
  input  logic [N_STICKY-1:0]   sticky,
  input  logic [N_LOWLATCH-1:0] lowl,
  output logic [WORD_W-1:0]     word
);
  always_comb begin
    word = '0;
    word[POS_RSVD]   = 1'b0;
    word[POS_XOVER]  = xover;
    word[POS_SIGDET] = lowl[1];
    word[POS_LOCK]   = lowl[0];
    for (int i = 0; i < N_STICKY; i++)
      word[sticky_pos(i)] = sticky[i];
  end
endmodule

// File: rtl/phy_status_bank.sv
module phy_status_bank
  import phy_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_stb,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0]     rd_data,
  input  logic                  mdix_swapped,
  input  logic                  rx_err_pulse,
  input  logic                  pol_inv_pulse,
  input  logic                  false_carrier_pulse,
  input  logic                  sig_det,
  input  logic                  dscr_lock,
  input  logic                  page_rcvd_pulse,
  input  logic                  irq_pulse,
  input  logic                  rem_fault_pulse,
  input  logic                  jabber_pulse
);
  logic [N_STICKY-1:0]   set_vec;
  logic [N_STICKY-1:0]   clr_vec;
  logic [N_STICKY-1:0]   sticky_q;
  logic [N_LOWLATCH-1:0] lowl_q;
  logic [WORD_W-1:0]     word;
  logic                  read_self;

  assign read_self = rd_stb && (rd_addr == ADR_STATUS);
  assign set_vec   = {rx_err_pulse, pol_inv_pulse, false_carrier_pulse,
                      page_rcvd_pulse, irq_pulse, rem_fault_pulse, jabber_pulse};

  genvar gi;
  generate
    for (gi = 0; gi < N_STICKY; gi++) begin : g_clr
      assign clr_vec[gi] = rd_stb && (rd_addr == sticky_clr_addr(gi));
    end
  endgenerate

  status_latch_hi #(.N(N_STICKY)) u_hi (
    .clk(clk), .rst(rst), .set_evt(set_vec), .clr(clr_vec), .q(sticky_q)
  );

  status_latch_lo #(.N(N_LOWLATCH)) u_lo (
    .clk(clk), .rst(rst), .live({sig_det, dscr_lock}), .rearm(read_self), .q(lowl_q)
  );

  status_word_pack u_pack (
    .xover(mdix_swapped), .sticky(sticky_q), .lowl(lowl_q), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (read_self)
      rd_data <= word;
    else
      rd_data <= '0;
  end
endmodule

// File: rtl/phy_status_bank_chk.sv
module phy_status_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd_stb,
  input logic [4:0]  rd_addr,
  input logic [15:0] rd_data,
  input logic        mdix_swapped,
  input logic        rx_err_pulse,
  input logic        pol_inv_pulse,
  input logic        sig_det
);
  logic rd_self;
  assign rd_self = rd_stb && (rd_addr == 5'h10);

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> rd_data == 16'h0);

  a_r2_quiet_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_self |=> rd_data == 16'h0);

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[15] == 1'b0);

  a_r3_live_xover: assert property (@(posedge clk) disable iff (rst)
    rd_self |=> rd_data[14] == $past(mdix_swapped));

  a_r4_rx_cleared: assert property (@(posedge clk) disable iff (rst)
    (rd_self && $past(!rst && rd_stb && rd_addr == 5'h15 && !rx_err_pulse) && !rx_err_pulse)
    |=> !rd_data[13]);

  a_r5_pol_cleared: assert property (@(posedge clk) disable iff (rst)
    (rd_self && $past(!rst && rd_stb && rd_addr == 5'h1A && !pol_inv_pulse))
    |=> !rd_data[12]);

  a_r7_drop_held: assert property (@(posedge clk) disable iff (rst)
    (rd_self && $past(!rst && !sig_det)) |=> !rd_data[10]);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    (rd_self && $past(!rst && rd_stb && rd_addr == 5'h15 && rx_err_pulse))
    |=> rd_data[13]);
endmodule

bind phy_status_bank phy_status_bank_chk u_chk (.*);

// File: tb/phy_status_bank_bench.sv
module phy_status_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic mdix = 0, rxe = 0, pol = 0, fc = 0, sd = 0, dl = 0, pg = 0, irq = 0, rf = 0, jab = 0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] m_lh = '0;   // expected latch-high bits at their word positions
  logic m_h10 = 0, m_h9 = 0;
  localparam logic [15:0] LH_MASK = 16'h39E0; // bits 13,12,11,8,7,6,5

  always #2 clk = ~clk;

  phy_status_bank u_phy_status_bank (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
    .mdix_swapped(mdix), .rx_err_pulse(rxe), .pol_inv_pulse(pol),
    .false_carrier_pulse(fc), .sig_det(sd), .dscr_lock(dl),
    .page_rcvd_pulse(pg), .irq_pulse(irq), .rem_fault_pulse(rf), .jabber_pulse(jab)
  );

  function automatic string tag_of(input int b);
    case (b)
      14: return "R3";
      13: return "R4";
      12: return "R5";
      11: return "R6";
      10, 9: return "R7";
      8: return "R8";
      7: return "R9";
      6, 5: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [15:0] model_word();
    return (m_lh & LH_MASK) | ({15'b0, mdix} << 14) | ({15'b0, m_h10} << 10) | ({15'b0, m_h9} << 9);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at following negedge.
  task automatic step(input logic stb, input logic [4:0] a, input logic [15:0] ev);
    logic [15:0] prev, exp;
    string t;
    rd_stb = stb; rd_addr = a;
    rxe = ev[13]; pol = ev[12]; fc = ev[11]; pg = ev[8]; irq = ev[7]; rf = ev[6]; jab = ev[5];
    @(posedge clk);
    prev = model_word();
    if (stb) begin
      case (a)
        5'h15: m_lh[13] = 1'b0;
        5'h1A: m_lh[12] = 1'b0;
        5'h14: m_lh[11] = 1'b0;
        5'h06: m_lh[8] = 1'b0;
        5'h12: m_lh[7] = 1'b0;
        5'h01: begin m_lh[6] = 1'b0; m_lh[5] = 1'b0; end
        default: ;
      endcase
    end
    m_lh = m_lh | (ev & LH_MASK);
    if (stb && a == 5'h10) begin m_h10 = sd; m_h9 = dl; end
    else begin m_h10 = m_h10 & sd; m_h9 = m_h9 & dl; end
    @(negedge clk);
    exp = (stb && a == 5'h10) ? prev : 16'h0;
    t = "R2";
    for (int b = 15; b >= 0; b--)
      if (rd_data[b] !== exp[b]) t = tag_of(b);
    chk(rd_data === exp, t, rd_data, exp);
    rd_stb = 0; rxe = 0; pol = 0; fc = 0; pg = 0; irq = 0; rf = 0; jab = 0;
  endtask

  task automatic clear_all();
    step(1, 5'h15, 0); step(1, 5'h1A, 0); step(1, 5'h14, 0);
    step(1, 5'h06, 0); step(1, 5'h12, 0); step(1, 5'h01, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pos [7] = '{13, 12, 11, 8, 7, 6, 5};
    // R1: events during reset are dropped, output zero
    @(negedge clk);
    rxe = 1; pol = 1; fc = 1; pg = 1; irq = 1; rf = 1; jab = 1; mdix = 0;
    repeat (3) @(negedge clk);
    chk(rd_data === 16'h0, "R1", rd_data, 16'h0);
    rst = 0; rxe = 0; pol = 0; fc = 0; pg = 0; irq = 0; rf = 0; jab = 0;
    step(1, 5'h10, 0);   // R1: word reads zero after reset
    // R7: first read after reset shows held 0, then re-armed from live
    sd = 1; dl = 1;
    step(1, 5'h10, 0);
    step(1, 5'h10, 0);
    sd = 0; step(0, 5'h00, 0); sd = 1;
    step(1, 5'h10, 0);   // R7: drop held through recovery
    step(1, 5'h10, 0);
    // R2: strobe low with status address yields zero
    step(0, 5'h10, 16'hFFFF);
    clear_all();
    // R3..R10, R12: each sticky bit against every address
    foreach (pos[k]) begin
      for (int a = 0; a < 32; a++) begin
        mdix = a[0]; sd = a[1]; dl = a[2];
        step(0, 5'h00, 16'h1 << pos[k]);
        step(1, 5'(a), 0);
        step(1, 5'h10, 0);
        clear_all();
      end
    end
    // R11: event and its own clearing read in one cycle
    foreach (pos[k]) begin
      logic [4:0] ca;
      case (pos[k])
        13: ca = 5'h15; 12: ca = 5'h1A; 11: ca = 5'h14;
        8: ca = 5'h06; 7: ca = 5'h12; default: ca = 5'h01;
      endcase
      step(1, ca, 16'h1 << pos[k]);
      step(1, 5'h10, 0);
      step(1, 5'h10, 0);
      chk(rd_data[pos[k]] === 1'b1, "R11", rd_data, 16'h1 << pos[k]);
      clear_all();
    end
    // R12: repeated status reads keep all sticky bits
    step(0, 5'h00, LH_MASK);
    step(1, 5'h10, 0);
    step(1, 5'h10, 0);
    chk((rd_data & LH_MASK) === LH_MASK, "R12", rd_data, LH_MASK);
    clear_all();
    step(1, 5'h10, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule